// File: doc/BRIEF.md
# SPI Register-Access Target Bridge

This block sits behind a SPI target port and converts each chip-select-bounded frame into accesses on a simple internal register bus. The frame opens with a one-byte header that gives the direction and the transfer length of 1 to 64 bytes. Three address bytes follow, then the data phase. Write bytes are collected in a local buffer and committed once the last one has arrived. A read is launched on the register bus as soon as the address is complete, so that the returned bytes can be shifted out during the data phase.

One register address is treated as a byte FIFO port. Any frame whose address falls on that word is broken into one single-byte bus access per data byte, all at the same address. Every other address receives a single bus access that is as wide as the transfer, capped at one 32-bit word. An optional pre-read input inserts one dummy byte ahead of the read data, which gives a slow register bus a whole SPI byte time to answer.

SPI runs in mode 0. SCLK, MOSI and chip select are brought into the system clock domain by two-flop synchronizers, so the system clock must run at least four times faster than SCLK. The register-bus request is valid/ready. The bridge holds a request, unchanged, until ready is seen, and keeps at most one access in flight. Read responses come back on a valid-only channel that the bridge always accepts.

Top module: `spi_regbridge`

## Requirements
- R1: Header byte: bit 7 = 1 selects a read and 0 selects a write. Bit 6 is ignored. Bits 5:0 hold the byte count minus one.
- R2: The three bytes after the header form the 24-bit bus address, most significant byte first.
- R3: A write frame issues no bus access until its final data byte has been received.
- R4: When (address & 0xFFC) equals FIFO_OFS (default 0x024), a frame of N bytes makes N accesses, each of size 1 and at the unchanged address, in data-byte order. Each access carries its byte in wdata[7:0], and a read takes rdata[7:0] from each access.
- R5: For any other address, one access is made with size = min(N,4). Data byte i occupies wdata[8i+7:8i]. Unwritten bytes are 0.
- R6: A read frame shifts out data byte i, taken from rdata[8i+7:8i], MSB first during the i-th data byte. The bytes come from the single read access, or for a FIFO address from the i-th read access.
- R7: MISO carries 0x01 during the header, address and write-data bytes. It carries 0xFF on any byte after the data phase.
- R8: With pre_read_en = 1, the first byte after the address returns 0xFF and does not count toward the length. Read data starts on the following byte.
- R9: A read data byte whose bus data has not arrived by that byte's first SCLK rise returns 0xFF. On a non-FIFO read, bytes after the fourth also return 0xFF.
- R10: Chip-select assertion clears header, address and buffer. Deassertion before the final write byte cancels the write, so no access is made.
- R11: While bus_req_valid is high and bus_req_ready is low, the request and all of its fields stay unchanged.
- R12: After reset, bus_req_valid is low and MISO is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI clock, mode 0 |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Controller-to-target data |
| spi_miso | output | 1 | Target-to-controller data |
| pre_read_en | input | 1 | Insert one dummy byte before read data |
| bus_req_valid | output | 1 | Register-bus request valid |
| bus_req_ready | input | 1 | Register-bus request accepted |
| bus_req_addr | output | 24 | Access address |
| bus_req_we | output | 1 | 1 = write, 0 = read |
| bus_req_size | output | 3 | Access width in bytes, 1 to 4 |
| bus_req_wdata | output | 32 | Write data, byte 0 in bits 7:0 |
| bus_rsp_valid | input | 1 | Read response valid, always accepted |
| bus_rsp_rdata | input | 32 | Read response data |

## Verification
A frame-state error shows up within one SPI byte as a filler value on MISO that is wrong. For example, 0x01 appears where 0xFF is expected after the data phase, or read data arrives one byte early or late when pre-read is on. An error in the access splitter or the buffer shows as soon as the frame's accesses are committed: the access count is wrong, or the size, the byte placement in wdata, or the address is wrong. Stale bytes left over from an earlier frame appear in the upper lanes of a narrow write. A bridge that drops or changes a request under back-pressure is caught on the first stalled cycle.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
  typedef enum logic [2:0] {
    FS_IDLE,
    FS_HDR,
    FS_ADDR,
    FS_GAP,
    FS_WDATA,
    FS_RDATA,
    FS_DONE
  } frame_st_e;

  localparam logic [7:0] FILL_BUSY = 8'h01;
  localparam logic [7:0] FILL_NONE = 8'hFF;
  localparam int HDR_DIR_BIT = 7;
endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta   <= RST_VAL;
      d_sync <= RST_VAL;
    end else begin
      meta   <= d_async;
      d_sync <= meta;
    end
  end
endmodule

// File: rtl/spi_rb_shift.sv
module spi_rb_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk_s,
  input  logic       mosi_s,
  input  logic       cs_n_s,
  input  logic [7:0] resp_byte,
  output logic       cs_fall,
  output logic       cs_rise,
  output logic       byte_valid,
  output logic [7:0] byte_data,
  output logic       miso
);
  logic       sclk_d, cs_d;
  logic [2:0] bit_cnt;
  logic [6:0] rx_sh;
  logic [7:0] tx_sh;
  logic       rise, fall;

  assign rise    = sclk_s & ~sclk_d;
  assign fall    = ~sclk_s & sclk_d;
  assign cs_fall = cs_d & ~cs_n_s;
  assign cs_rise = ~cs_d & cs_n_s;
  assign miso    = tx_sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d     <= 1'b0;
      cs_d       <= 1'b1;
      bit_cnt    <= '0;
      rx_sh      <= '0;
      tx_sh      <= 8'hFF;
      byte_valid <= 1'b0;
      byte_data  <= '0;
    end else begin
      sclk_d     <= sclk_s;
      cs_d       <= cs_n_s;
      byte_valid <= 1'b0;
      if (cs_n_s) begin
        bit_cnt <= '0;
        tx_sh   <= resp_byte;
      end else begin
        if (rise) begin
          rx_sh   <= {rx_sh[5:0], mosi_s};
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            byte_valid <= 1'b1;
            byte_data  <= {rx_sh, mosi_s};
          end
        end
        // between bytes the next response is tracked until the first rise
        if (bit_cnt == 3'd0 && !rise) tx_sh <= resp_byte;
        else if (fall && bit_cnt != 3'd0) tx_sh <= {tx_sh[6:0], 1'b1};
      end
    end
  end
endmodule

// File: rtl/spi_rb_frame.sv
module spi_rb_frame
  import spi_rb_pkg::*;
#(
  parameter int MAX_LEN = 64,
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter logic [11:0] FIFO_OFS = 12'h024
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cs_fall,
  input  logic                          cs_rise,
  input  logic                          byte_valid,
  input  logic [7:0]                    byte_data,
  input  logic                          pre_read,
  output logic [7:0]                    resp_byte,
  output logic                          req_valid,
  input  logic                          req_ready,
  output logic [ADDR_W-1:0]             req_addr,
  output logic                          req_we,
  output logic [$clog2(DATA_W/8):0]     req_size,
  output logic [DATA_W-1:0]             req_wdata,
  input  logic                          rsp_valid,
  input  logic [DATA_W-1:0]             rsp_rdata
);
  localparam int LEN_W  = $clog2(MAX_LEN);
  localparam int CNT_W  = LEN_W + 1;
  localparam int BPW    = DATA_W / 8;
  localparam int SIZE_W = $clog2(BPW) + 1;
  localparam int ABYTES = ADDR_W / 8;
  localparam int AC_W   = $clog2(ABYTES);

  frame_st_e          st;
  logic               dir_rd;
  logic [LEN_W-1:0]   len_m1;
  logic [ADDR_W-1:0]  addr;
  logic [AC_W-1:0]    acnt;
  logic [CNT_W-1:0]   idx, k, fetched;
  logic [7:0]         buf_q [MAX_LEN];
  logic               eng_we, wait_rsp;

  logic [CNT_W-1:0]   len_q, n_acc;
  logic               fifo_hit;
  logic [SIZE_W-1:0]  eng_size;

  assign len_q    = CNT_W'(len_m1) + CNT_W'(1);
  assign fifo_hit = (addr[11:0] & 12'hFFC) == FIFO_OFS;
  assign n_acc    = fifo_hit ? len_q : CNT_W'(1);
  assign eng_size = fifo_hit ? SIZE_W'(1)
                  : (len_q > CNT_W'(BPW)) ? SIZE_W'(BPW) : len_q[SIZE_W-1:0];

  assign req_addr = addr;
  assign req_we   = eng_we;
  assign req_size = eng_size;

  for (genvar b = 0; b < BPW; b++) begin : g_wd
    if (b == 0) begin : g_lane0
      assign req_wdata[7:0] = fifo_hit ? buf_q[k[LEN_W-1:0]] : buf_q[0];
    end else begin : g_lane
      assign req_wdata[8*b+:8] = fifo_hit ? 8'h00 : buf_q[b];
    end
  end

  always_comb begin
    case (st)
      FS_HDR, FS_ADDR, FS_WDATA: resp_byte = FILL_BUSY;
      FS_RDATA: resp_byte = (idx < fetched) ? buf_q[idx[LEN_W-1:0]] : FILL_NONE;
      default:  resp_byte = FILL_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= FS_IDLE;
      dir_rd    <= 1'b0;
      len_m1    <= '0;
      addr      <= '0;
      acnt      <= '0;
      idx       <= '0;
      k         <= '0;
      fetched   <= '0;
      eng_we    <= 1'b0;
      wait_rsp  <= 1'b0;
      req_valid <= 1'b0;
      for (int i = 0; i < MAX_LEN; i++) buf_q[i] <= '0;
    end else begin
      // bus sequencer: one access in flight, request held until accepted
      if (req_valid && req_ready) begin
        req_valid <= 1'b0;
        if (eng_we) begin
          if (k + CNT_W'(1) != n_acc) begin
            k         <= k + CNT_W'(1);
            req_valid <= 1'b1;
          end
        end else begin
          wait_rsp <= 1'b1;
        end
      end
      if (wait_rsp && rsp_valid) begin
        wait_rsp <= 1'b0;
        if (fifo_hit) begin
          buf_q[k[LEN_W-1:0]] <= rsp_rdata[7:0];
          fetched             <= k + CNT_W'(1);
        end else begin
          for (int b = 0; b < BPW; b++) buf_q[b] <= rsp_rdata[8*b+:8];
          fetched <= CNT_W'(eng_size);
        end
        if (k + CNT_W'(1) != n_acc) begin
          k         <= k + CNT_W'(1);
          req_valid <= 1'b1;
        end
      end

      // frame decoder
      if (cs_fall) begin
        st      <= FS_HDR;
        dir_rd  <= 1'b0;
        len_m1  <= '0;
        addr    <= '0;
        acnt    <= '0;
        idx     <= '0;
        fetched <= '0;
        for (int i = 0; i < MAX_LEN; i++) buf_q[i] <= '0;
      end else if (cs_rise) begin
        st <= FS_IDLE;
      end else if (byte_valid) begin
        case (st)
          FS_HDR: begin
            dir_rd <= byte_data[HDR_DIR_BIT];
            len_m1 <= byte_data[LEN_W-1:0];
            st     <= FS_ADDR;
          end
          FS_ADDR: begin
            addr <= {addr[ADDR_W-9:0], byte_data};
            acnt <= acnt + AC_W'(1);
            if (acnt == AC_W'(ABYTES - 1)) begin
              if (dir_rd) begin
                st        <= pre_read ? FS_GAP : FS_RDATA;
                req_valid <= 1'b1;
                eng_we    <= 1'b0;
                k         <= '0;
                fetched   <= '0;
              end else begin
                st <= FS_WDATA;
              end
            end
          end
          FS_GAP: st <= FS_RDATA;
          FS_WDATA: begin
            buf_q[idx[LEN_W-1:0]] <= byte_data;
            idx <= idx + CNT_W'(1);
            if (idx + CNT_W'(1) == len_q) begin
              st        <= FS_DONE;
              req_valid <= 1'b1;
              eng_we    <= 1'b1;
              k         <= '0;
            end
          end
          FS_RDATA: begin
            idx <= idx + CNT_W'(1);
            if (idx + CNT_W'(1) == len_q) st <= FS_DONE;
          end
          default: st <= FS_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_regbridge.sv
module spi_regbridge #(
  parameter int MAX_LEN = 64,
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter logic [11:0] FIFO_OFS = 12'h024
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      spi_sclk,
  input  logic                      spi_cs_n,
  input  logic                      spi_mosi,
  output logic                      spi_miso,
  input  logic                      pre_read_en,
  output logic                      bus_req_valid,
  input  logic                      bus_req_ready,
  output logic [ADDR_W-1:0]         bus_req_addr,
  output logic                      bus_req_we,
  output logic [$clog2(DATA_W/8):0] bus_req_size,
  output logic [DATA_W-1:0]         bus_req_wdata,
  input  logic                      bus_rsp_valid,
  input  logic [DATA_W-1:0]         bus_rsp_rdata
);
  logic [2:0] pins_s;
  logic       cs_fall, cs_rise, byte_valid;
  logic [7:0] byte_data, resp_byte;

  spi_rb_sync #(.W(3), .RST_VAL(3'b001)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({spi_sclk, spi_mosi, spi_cs_n}),
    .d_sync  (pins_s)
  );

  spi_rb_shift u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk_s     (pins_s[2]),
    .mosi_s     (pins_s[1]),
    .cs_n_s     (pins_s[0]),
    .resp_byte  (resp_byte),
    .cs_fall    (cs_fall),
    .cs_rise    (cs_rise),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .miso       (spi_miso)
  );

  spi_rb_frame #(
    .MAX_LEN(MAX_LEN), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FIFO_OFS(FIFO_OFS)
  ) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_fall    (cs_fall),
    .cs_rise    (cs_rise),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .pre_read   (pre_read_en),
    .resp_byte  (resp_byte),
    .req_valid  (bus_req_valid),
    .req_ready  (bus_req_ready),
    .req_addr   (bus_req_addr),
    .req_we     (bus_req_we),
    .req_size   (bus_req_size),
    .req_wdata  (bus_req_wdata),
    .rsp_valid  (bus_rsp_valid),
    .rsp_rdata  (bus_rsp_rdata)
  );
endmodule

// File: rtl/spi_regbridge_chk.sv
module spi_regbridge_chk #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter logic [11:0] FIFO_OFS = 12'h024
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      bus_req_valid,
  input logic                      bus_req_ready,
  input logic [ADDR_W-1:0]         bus_req_addr,
  input logic                      bus_req_we,
  input logic [$clog2(DATA_W/8):0] bus_req_size,
  input logic [DATA_W-1:0]         bus_req_wdata,
  input logic                      bus_rsp_valid
);
  localparam int BPW = DATA_W / 8;

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && !bus_req_ready |=> bus_req_valid && $stable(bus_req_addr)
      && $stable(bus_req_we) && $stable(bus_req_size) && $stable(bus_req_wdata));

  p_size_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid |-> bus_req_size >= 1 && int'(bus_req_size) <= BPW);

  p_fifo_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && ((bus_req_addr[11:0] & 12'hFFC) == FIFO_OFS) |-> bus_req_size == 1);

  p_one_flight_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rsp_valid |-> !bus_req_valid);

  p_reset_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !bus_req_valid);
endmodule

bind spi_regbridge spi_regbridge_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FIFO_OFS(FIFO_OFS)
) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_req_valid (bus_req_valid),
  .bus_req_ready (bus_req_ready),
  .bus_req_addr  (bus_req_addr),
  .bus_req_we    (bus_req_we),
  .bus_req_size  (bus_req_size),
  .bus_req_wdata (bus_req_wdata),
  .bus_rsp_valid (bus_rsp_valid)
);

// File: tb/test_spi_regbridge.sv
module test_spi_regbridge;
  localparam int HALF = 60;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, pre_rd = 1'b0;
  logic        miso;
  logic        req_valid, req_ready, req_we;
  logic [23:0] req_addr;
  logic [2:0]  req_size;
  logic [31:0] req_wdata;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_rdata = '0;

  always #5 clk = ~clk;

  spi_regbridge i_spi_regbridge (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .pre_read_en(pre_rd), .bus_req_valid(req_valid),
    .bus_req_ready(req_ready), .bus_req_addr(req_addr), .bus_req_we(req_we),
    .bus_req_size(req_size), .bus_req_wdata(req_wdata), .bus_rsp_valid(rsp_valid),
    .bus_rsp_rdata(rsp_rdata)
  );

  // register-bus model
  int          stall_cfg = 0, lat_cfg = 1;
  logic        clr = 1'b0;
  int          wait_cnt = 0, log_n = 0, rd_cnt = 0, pend_cnt = 0, hold_bad = 0;
  logic        pending = 1'b0, prev_hold = 1'b0;
  logic [31:0] pend_data = '0, p_wd = '0;
  logic [23:0] p_addr = '0;
  logic [23:0] log_addr [16];
  logic [2:0]  log_size [16];
  logic [31:0] log_wd   [16];
  logic [31:0] rd_word = 32'h8765_4321;

  assign req_ready = (wait_cnt >= stall_cfg);

  always @(posedge clk) begin
    rsp_valid <= 1'b0;
    wait_cnt  <= (req_valid && !req_ready) ? wait_cnt + 1 : 0;
    if (prev_hold && !(req_valid && req_addr == p_addr && req_wdata == p_wd))
      hold_bad <= hold_bad + 1;
    prev_hold <= req_valid && !req_ready;
    p_addr    <= req_addr;
    p_wd      <= req_wdata;
    if (req_valid && req_ready) begin
      if (req_we) begin
        if (log_n < 16) begin
          log_addr[log_n] <= req_addr;
          log_size[log_n] <= req_size;
          log_wd[log_n]   <= req_wdata;
        end
        log_n <= log_n + 1;
      end else begin
        pending   <= 1'b1;
        pend_cnt  <= lat_cfg;
        pend_data <= rd_word + rd_cnt;
        rd_cnt    <= rd_cnt + 1;
      end
    end
    if (pending) begin
      if (pend_cnt <= 1) begin
        pending   <= 1'b0;
        rsp_valid <= 1'b1;
        rsp_rdata <= pend_data;
      end else pend_cnt <= pend_cnt - 1;
    end
    if (clr) begin
      log_n  <= 0;
      rd_cnt <= 0;
    end
  end

  int total = 0, bad = 0;
  logic [7:0] tx_q [80];
  logic [7:0] rx_q [80];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_model();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic spi_start();
    @(negedge clk);
    cs_n = 1'b0;
    #(2*HALF);
  endtask

  task automatic spi_xfer(input logic [7:0] o, output logic [7:0] r);
    for (int b = 7; b >= 0; b--) begin
      mosi = o[b];
      #HALF;
      r[b] = miso;
      sclk = 1'b1;
      #HALF;
      sclk = 1'b0;
    end
  endtask

  task automatic spi_stop();
    #HALF;
    cs_n = 1'b1;
    #(4*HALF);
    repeat (80) @(negedge clk);
  endtask

  task automatic send(input int first, input int cnt);
    for (int i = first; i < first + cnt; i++) spi_xfer(tx_q[i], rx_q[i]);
  endtask

  task automatic load_head(input logic [7:0] h, input logic [23:0] a);
    tx_q[0] = h; tx_q[1] = a[23:16]; tx_q[2] = a[15:8]; tx_q[3] = a[7:0];
    for (int i = 4; i < 80; i++) tx_q[i] = 8'hFF;
  endtask

  // {header, address, data bytes (byte 0 in bits 7:0)}
  localparam logic [63:0] VEC [7] = '{
    {8'h03, 24'h000F00, 32'h1122_3344},
    {8'h40, 24'h000018, 32'h0000_005A},
    {8'h02, 24'h000027, 32'h00C0_FFEE},
    {8'h83, 24'h123400, 32'h0},
    {8'hC1, 24'hAB0024, 32'h0},
    {8'h81, 24'h000100, 32'h0},
    {8'h85, 24'h000500, 32'h0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R12 request idle after reset", {31'b0, req_valid}, 32'd0);
    check("R12 miso high in reset", {31'b0, miso}, 32'd1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R12 request idle after release", {31'b0, req_valid}, 32'd0);

    // vector table
    for (int v = 0; v < 7; v++) begin
      logic [7:0]  h;
      logic [23:0] a;
      logic [31:0] d;
      int          n, sz;
      logic        fifo;
      h = VEC[v][63:56]; a = VEC[v][55:32]; d = VEC[v][31:0];
      n = int'(h[5:0]) + 1;
      fifo = (a[11:0] & 12'hFFC) == 12'h024;
      sz = (n > 4) ? 4 : n;
      clear_model();
      load_head(h, a);
      if (!h[7]) for (int i = 0; i < n; i++) tx_q[4+i] = d[8*i+:8];
      spi_start(); send(0, 4 + n); spi_stop();
      for (int i = 0; i < 4; i++) check("R7 filler on header/address", {24'b0, rx_q[i]}, 32'h01);
      if (!h[7]) begin
        for (int i = 0; i < n; i++) check("R7 filler on write data", {24'b0, rx_q[4+i]}, 32'h01);
        if (fifo) begin
          check("R4 fifo access count", log_n, n);
          for (int i = 0; i < n; i++) begin
            check("R4 fifo address unchanged R2", {8'b0, log_addr[i]}, {8'b0, a});
            check("R4 fifo size one", {29'b0, log_size[i]}, 32'd1);
            check("R4 fifo byte order", log_wd[i], {24'b0, d[8*i+:8]});
          end
        end else begin
          check("R5 single access R1", log_n, 1);
          check("R2 address", {8'b0, log_addr[0]}, {8'b0, a});
          check("R5 access size", {29'b0, log_size[0]}, sz);
          check("R5 byte lanes, R10 cleared upper", log_wd[0],
                (sz == 4) ? d : (d & ((32'h1 << (8*sz)) - 1)));
        end
      end else begin
        for (int i = 0; i < n; i++) begin
          logic [31:0] w;
          logic [7:0]  e;
          w = rd_word + (fifo ? i : 0);
          e = fifo ? w[7:0] : (i < 4 ? w[8*i+:8] : 8'hFF);
          check(fifo ? "R4 fifo read byte" : (i < 4 ? "R6 read byte" : "R9 read past word"),
                {24'b0, rx_q[4+i]}, {24'b0, e});
        end
        check("R1 read makes no write", log_n, 0);
      end
    end

    // R3: commit only after last byte
    clear_model();
    load_head(8'h02, 24'h000200);
    tx_q[4] = 8'hAA; tx_q[5] = 8'hBB; tx_q[6] = 8'hCC;
    spi_start(); send(0, 6);
    repeat (40) @(negedge clk);
    check("R3 no access before last byte", log_n, 0);
    send(6, 1);
    repeat (40) @(negedge clk);
    check("R3 access after last byte", log_n, 1);
    check("R3 write data", log_wd[0], 32'h00CC_BBAA);
    spi_stop();

    // R10: aborted write
    clear_model();
    load_head(8'h03, 24'h000300);
    tx_q[4] = 8'h12; tx_q[5] = 8'h34;
    spi_start(); send(0, 6); spi_stop();
    check("R10 aborted write dropped", log_n, 0);

    // R11: back-pressure on FIFO write
    clear_model();
    stall_cfg = 3;
    load_head(8'h02, 24'h000024);
    tx_q[4] = 8'h01; tx_q[5] = 8'h02; tx_q[6] = 8'h03;
    spi_start(); send(0, 7); spi_stop();
    stall_cfg = 0;
    check("R11 all stalled accesses delivered", log_n, 3);
    for (int i = 0; i < 3; i++) check("R11 stalled data intact", log_wd[i], i + 1);
    check("R11 request held while stalled", hold_bad, 0);

    // R9: slow response
    clear_model();
    lat_cfg = 30;
    load_head(8'h81, 24'h000400);
    spi_start(); send(0, 6); spi_stop();
    check("R9 late first byte", {24'b0, rx_q[4]}, 32'hFF);
    check("R9 second byte arrives", {24'b0, rx_q[5]}, {24'b0, rd_word[15:8]});

    // R8: pre-read with the same slow bus
    clear_model();
    pre_rd = 1'b1;
    load_head(8'h81, 24'h000600);
    spi_start(); send(0, 7); spi_stop();
    pre_rd = 1'b0;
    lat_cfg = 1;
    check("R8 dummy byte", {24'b0, rx_q[4]}, 32'hFF);
    check("R8 data byte 0", {24'b0, rx_q[5]}, {24'b0, rd_word[7:0]});
    check("R8 data byte 1", {24'b0, rx_q[6]}, {24'b0, rd_word[15:8]});

    // R7: bytes after data phase
    clear_model();
    load_head(8'h80, 24'h000700);
    spi_start(); send(0, 7); spi_stop();
    check("R6 single read byte", {24'b0, rx_q[4]}, {24'b0, rd_word[7:0]});
    check("R7 after data phase", {24'b0, rx_q[5]}, 32'hFF);
    check("R7 outside frame", {24'b0, rx_q[6]}, 32'hFF);
    check("R7 read made one access", rd_cnt, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule